// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects the interrupt sources of a small 8-bit processor, keeps a request flag and an enable flag for each maskable source, and picks one winner by fixed priority. It presents the winner's 16-bit vector address and an interrupt-pending line to the core. Eight on-chip events arrive as one-cycle pulses: display-done, vertical sync, four timer overflows, serial, two-wire bus and a periodic tick. Three external pins pass through a synchronizer and an edge detector. For each pin, a polarity bit selects whether a rising or a falling transition counts as the event.

Software reads the request, enable and polarity registers through a small register port. A write to a request register can only drop flags, never raise them. The core returns its interrupt-disable flag and a one-cycle acknowledge. The acknowledge clears the request of the source whose vector is on the output in that cycle. The software-break request from the core has no enable bit, ignores the disable flag and ranks below every maskable source. When nothing is pending, the vector output shows the reset vector.

Top module: `irq_vec_ctl`

## Requirements
- R1: After reset every request, enable and polarity bit reads 0, `irq_o` is 0 and `vector_o` is 16'hFFFE (reset vector).
- R2: A one-cycle peripheral pulse sets that source's request bit at the next rising clock edge.
- R3: An external pin event sets its request bit on the third rising edge after the pin changes. Polarity 0 accepts only a rising transition and polarity 1 accepts only a falling transition.
- R4: A write to a request register (address 0 or 1) clears every bit written as 0 and leaves every bit written as 1 unchanged. It never sets a bit.
- R5: Enable registers (address 2 for slots 0-7, address 3 for slots 8-11) take any written value on used slots. Unused slots read 0.
- R6: `irq_o` rises for a maskable source only when its request and enable bits are both 1 and `iflag_i` is 0.
- R7: Among accepted maskable sources the winner follows this order, from highest to lowest, with these vectors: display-done FFFC, pin 2 FFFA, pin 1 FFF8, timer 4 FFF4, tick FFF2, vertical sync FFF0, timer 3 FFEE, timer 2 FFEC, timer 1 FFEA, serial FFE8, two-wire bus FFE6, pin 3 FFE4.
- R8: `brk_i` drives `irq_o` high whatever the enables and `iflag_i` are. It yields vector FFDE only when no maskable source is accepted.
- R9: `ack_i` clears only the request bit of the source whose vector is presented in the same cycle.
- R10: A hardware set and a software clear of the same request bit in one cycle leave the bit at 1.
- R11: The polarity register (address 4) stores only bits 3, 4 and 5, which serve pins 1, 2 and 3. Its other bits read 0.
- R12: Request slot k holds the k-th source of the R7 order. Slots 0-7 are bits 0-7 of address 0 and slots 8-11 are bits 0-3 of address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pin_i | input | 3 | External interrupt pins 1, 2, 3 (bit 0 = pin 1) |
| disp_done_i | input | 1 | Display-done pulse |
| vsync_i | input | 1 | Vertical sync pulse |
| tmr_ovf_i | input | 4 | Timer overflow pulses (bit 0 = timer 1) |
| ser_i | input | 1 | Serial transfer pulse |
| twb_i | input | 1 | Two-wire bus event pulse |
| tick_i | input | 1 | Periodic tick pulse |
| brk_i | input | 1 | Software-break request from the core |
| iflag_i | input | 1 | Core interrupt-disable flag |
| ack_i | input | 1 | Interrupt acknowledge |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt pending |
| vector_o | output | 16 | Vector address of the winner |

## Verification
The hardest case to reach is a hardware set and a software clear landing on the same request bit in the same clock. The bench drives a serial pulse and a zero write to the upper request register in one cycle. It then reads the bit back to confirm that the set took effect. The priority chain is walked by raising several requests at once and acknowledging them one by one. After each acknowledge, the next lower vector must appear. The pin polarity path is covered by switching the edge selection and driving both transitions, each of which must be accepted or ignored.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int NSRC   = 12;
    localparam int NPIN   = 3;
    localparam int REG_W  = 8;
    localparam int NREG   = 2;
    localparam int FLAT_W = NREG * REG_W;
    localparam int POL_LSB = 3;

    localparam logic [15:0] VEC_RESET = 16'hFFFE;
    localparam logic [15:0] VEC_BRK   = 16'hFFDE;

    localparam int unsigned SLOT_MAP_DEF [NSRC] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11};

    function automatic logic [15:0] src_vector(input int idx);
        logic [7:0] lo;
        case (idx)
            0:  lo = 8'hFC;
            1:  lo = 8'hFA;
            2:  lo = 8'hF8;
            3:  lo = 8'hF4;
            4:  lo = 8'hF2;
            5:  lo = 8'hF0;
            6:  lo = 8'hEE;
            7:  lo = 8'hEC;
            8:  lo = 8'hEA;
            9:  lo = 8'hE8;
            10: lo = 8'hE6;
            default: lo = 8'hE4;
        endcase
        return {8'hFF, lo};
    endfunction

    typedef struct packed {
        logic [FLAT_W-1:0] req;
        logic [FLAT_W-1:0] en;
        logic [NPIN-1:0]   pol;
    } regs_t;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
    parameter int N = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] edge_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        for (int i = 0; i < N; i++) begin
            edge_o[i] = pol_i[i] ? (st_q.prev[i] & ~st_q.s2[i])
                                 : (~st_q.prev[i] & st_q.s2[i]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R3
    edge_one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_o != '0) |=> ((edge_o & $past(edge_o)) == '0));
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_ctl_pkg::*;
(
    input  logic [NSRC-1:0] active_i,
    input  logic            brk_i,
    output logic            any_o,
    output logic [NSRC-1:0] win_oh_o,
    output logic [15:0]     vector_o
);
    always_comb begin
        any_o    = 1'b0;
        win_oh_o = '0;
        vector_o = brk_i ? VEC_BRK : VEC_RESET;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (active_i[i]) begin
                any_o    = 1'b1;
                win_oh_o = '0;
                win_oh_o[i] = 1'b1;
                vector_o = src_vector(i);
            end
        end
    end

    // R7
    winner_onehot_chk: assert final ($onehot0(win_oh_o));
endmodule

// File: rtl/irq_vec_ctl.sv
module irq_vec_ctl
    import irq_ctl_pkg::*;
#(
    parameter int unsigned SLOT_MAP [NSRC] = SLOT_MAP_DEF
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [2:0]  pin_i,
    input  logic        disp_done_i,
    input  logic        vsync_i,
    input  logic [3:0]  tmr_ovf_i,
    input  logic        ser_i,
    input  logic        twb_i,
    input  logic        tick_i,
    input  logic        brk_i,
    input  logic        iflag_i,
    input  logic        ack_i,
    input  logic        wr_en_i,
    input  logic [2:0]  addr_i,
    input  logic [7:0]  wr_data_i,
    output logic [7:0]  rd_data_o,
    output logic        irq_o,
    output logic [15:0] vector_o
);
    localparam logic [2:0] A_REQ0 = 3'd0;
    localparam logic [2:0] A_REQ1 = 3'd1;
    localparam logic [2:0] A_EN0  = 3'd2;
    localparam logic [2:0] A_EN1  = 3'd3;
    localparam logic [2:0] A_POL  = 3'd4;

    regs_t r_d, r_q;

    logic [NPIN-1:0]   pin_edge;
    logic [NSRC-1:0]   src_pulse;
    logic [NSRC-1:0]   active;
    logic [NSRC-1:0]   win_oh;
    logic              any_act;
    logic [FLAT_W-1:0] set_flat, ack_flat, used_flat, sw_clr;

    irq_pin_edge #(.N(NPIN)) u_pins (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .pol_i  (r_q.pol),
        .edge_o (pin_edge)
    );

    // Sources in priority order
    assign src_pulse = {pin_edge[2], twb_i, ser_i, tmr_ovf_i[0], tmr_ovf_i[1],
                        tmr_ovf_i[2], vsync_i, tick_i, tmr_ovf_i[3],
                        pin_edge[0], pin_edge[1], disp_done_i};

    irq_pick u_pick (
        .active_i (active),
        .brk_i    (brk_i),
        .any_o    (any_act),
        .win_oh_o (win_oh),
        .vector_o (vector_o)
    );

    always_comb begin
        set_flat  = '0;
        ack_flat  = '0;
        used_flat = '0;
        for (int i = 0; i < NSRC; i++) begin
            set_flat[SLOT_MAP[i]]  = src_pulse[i];
            ack_flat[SLOT_MAP[i]]  = ack_i & win_oh[i];
            used_flat[SLOT_MAP[i]] = 1'b1;
            active[i] = r_q.req[SLOT_MAP[i]] & r_q.en[SLOT_MAP[i]] & ~iflag_i;
        end
        irq_o = any_act | brk_i;

        sw_clr = '0;
        r_d    = r_q;
        if (wr_en_i) begin
            case (addr_i)
                A_REQ0: sw_clr[REG_W-1:0]      = ~wr_data_i;
                A_REQ1: sw_clr[FLAT_W-1:REG_W] = ~wr_data_i;
                A_EN0:  r_d.en[REG_W-1:0]      = wr_data_i & used_flat[REG_W-1:0];
                A_EN1:  r_d.en[FLAT_W-1:REG_W] = wr_data_i & used_flat[FLAT_W-1:REG_W];
                A_POL:  r_d.pol = wr_data_i[POL_LSB +: NPIN];
                default: ;
            endcase
        end
        r_d.req = (r_q.req & ~sw_clr & ~ack_flat) | set_flat;

        case (addr_i)
            A_REQ0:  rd_data_o = r_q.req[REG_W-1:0];
            A_REQ1:  rd_data_o = r_q.req[FLAT_W-1:REG_W];
            A_EN0:   rd_data_o = r_q.en[REG_W-1:0];
            A_EN1:   rd_data_o = r_q.en[FLAT_W-1:REG_W];
            A_POL:   rd_data_o = 8'(r_q.pol) << POL_LSB;
            default: rd_data_o = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_flat != '0) |=> ((r_q.req & $past(set_flat)) == $past(set_flat)));

    // R4
    no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((r_q.req & ~$past(r_q.req) & ~$past(set_flat)) == '0));

    // R9
    ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && any_act && ((set_flat & ack_flat) == '0))
        |=> ((r_q.req & $past(ack_flat)) == '0));

    // R6
    masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iflag_i && !brk_i) |-> !irq_o);

    // R8
    brk_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (brk_i && iflag_i) |-> (irq_o && vector_o == VEC_BRK));
endmodule

// File: tb/sim_irq_vec_ctl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pin = '0;
    logic        disp_done = 0, vsync = 0, ser = 0, twb = 0, tick = 0;
    logic [3:0]  tmr = '0;
    logic        brk = 0, iflag = 0, ack = 0, wr_en = 0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;
    logic [15:0] vec;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        int          kind;
        logic [15:0] exp;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    irq_vec_ctl u0 (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .disp_done_i(disp_done),
        .vsync_i(vsync), .tmr_ovf_i(tmr), .ser_i(ser), .twb_i(twb), .tick_i(tick),
        .brk_i(brk), .iflag_i(iflag), .ack_i(ack), .wr_en_i(wr_en), .addr_i(addr),
        .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq), .vector_o(vec)
    );

    // Monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = {8'h00, rdata};
                1: act = vec;
                default: act = {15'h0, irq};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_item(string tag, int kind, logic [15:0] exp);
        item_t it;
        it.tag = tag; it.kind = kind; it.exp = exp;
        sb.push_back(it);
        wait (sb.size() == 0);
        step();
    endtask

    task automatic check_rd(string tag, logic [2:0] a, logic [7:0] exp);
        addr = a;
        expect_item(tag, 0, {8'h00, exp});
    endtask

    task automatic check_vec(string tag, logic [15:0] exp);
        expect_item(tag, 1, exp);
    endtask

    task automatic check_irq(string tag, logic exp);
        expect_item(tag, 2, {15'h0, exp});
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1;
        step();
        wr_en = 0;
    endtask

    task automatic do_ack();
        ack = 1;
        step();
        ack = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        step();
        // R1 reset state
        for (int a = 0; a < 5; a++) check_rd("R1 regs", 3'(a), 8'h00);
        check_irq("R1 irq", 1'b0);
        check_vec("R1 vector", 16'hFFFE);

        // R5 enables
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFF);
        check_rd("R5 en lo", 3'd2, 8'hFF);
        check_rd("R5 en hi used slots", 3'd3, 8'h0F);
        wr(3'd2, 8'h00);
        check_rd("R5 en cleared", 3'd2, 8'h00);
        wr(3'd2, 8'hFF);

        // R2 / R12 peripheral pulses
        tmr[0] = 1; step(); tmr[0] = 0;
        check_rd("R2 R12 timer1 slot 8", 3'd1, 8'h01);
        vsync = 1; step(); vsync = 0;
        check_rd("R2 R12 vsync slot 5", 3'd0, 8'h20);

        // R7 priority: vsync over timer1
        check_vec("R7 vsync vector", 16'hFFF0);
        check_irq("R6 irq accepted", 1'b1);
        iflag = 1;
        check_irq("R6 iflag blocks", 1'b0);
        iflag = 0;

        // R9 ack clears only the presented source
        do_ack();
        check_rd("R9 vsync cleared", 3'd0, 8'h00);
        check_rd("R9 timer1 kept", 3'd1, 8'h01);
        check_vec("R9 R7 timer1 vector", 16'hFFEA);

        // R4 software writes only clear
        wr(3'd1, 8'hFF);
        check_rd("R4 write ones keeps", 3'd1, 8'h01);
        wr(3'd0, 8'hFF);
        check_rd("R4 write ones never sets", 3'd0, 8'h00);
        wr(3'd1, 8'h00);
        check_rd("R4 write zero clears", 3'd1, 8'h00);
        check_irq("R4 irq low", 1'b0);
        check_vec("R4 idle vector", 16'hFFFE);

        // R10 set beats software clear
        ser = 1; addr = 3'd1; wdata = 8'h00; wr_en = 1;
        step();
        ser = 0; wr_en = 0;
        check_rd("R10 set wins", 3'd1, 8'h02);

        // R3 pin 2 rising with polarity 0
        pin[1] = 1;
        step(2);
        check_rd("R3 not before third edge", 3'd0, 8'h00);
        wr(3'd0, 8'h00);
        pin[1] = 0; pin[1] = 0;
        pin[1] = 1; pin[1] = 1;
        pin[1] = 0;
        step(5);
        wr(3'd0, 8'h00);
        pin[1] = 1;
        step(3);
        check_rd("R3 rising accepted", 3'd0, 8'h02);
        wr(3'd0, 8'h00);
        pin[1] = 0;
        step(5);
        check_rd("R3 falling ignored at pol 0", 3'd0, 8'h00);
        wr(3'd4, 8'h10);
        check_rd("R11 pin2 polarity bit4", 3'd4, 8'h10);
        pin[1] = 1;
        step(5);
        check_rd("R3 rising ignored at pol 1", 3'd0, 8'h00);
        pin[1] = 0;
        step(3);
        check_rd("R3 falling accepted", 3'd0, 8'h02);
        check_vec("R7 pin2 vector", 16'hFFFA);
        wr(3'd0, 8'h00);

        // R11 only bits 3..5 stored
        wr(3'd4, 8'hFF);
        check_rd("R11 polarity mask", 3'd4, 8'h38);
        wr(3'd4, 8'h00);

        // R7 priority chain: timer4, tick, serial(pending), two-wire bus
        tmr[3] = 1; tick = 1; twb = 1; step(); tmr[3] = 0; tick = 0; twb = 0;
        check_vec("R7 timer4 first", 16'hFFF4);
        do_ack();
        check_vec("R7 tick next", 16'hFFF2);
        do_ack();
        check_vec("R7 serial next", 16'hFFE8);
        do_ack();
        check_vec("R7 two-wire next", 16'hFFE6);
        disp_done = 1; step(); disp_done = 0;
        check_vec("R7 display-done top", 16'hFFFC);
        do_ack();
        do_ack();
        check_vec("R7 chain drained", 16'hFFFE);

        // R8 software break
        brk = 1;
        check_irq("R8 brk irq", 1'b1);
        check_vec("R8 brk vector", 16'hFFDE);
        tmr[1] = 1; step(); tmr[1] = 0;
        check_vec("R8 maskable beats brk", 16'hFFEC);
        iflag = 1;
        check_vec("R8 brk under iflag", 16'hFFDE);
        check_irq("R8 brk ignores iflag", 1'b1);
        brk = 0; iflag = 0;

        // R6 enable off
        wr(3'd2, 8'h00);
        check_irq("R6 enable off", 1'b0);
        check_rd("R6 request still held", 3'd0, 8'h80);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule